// File: doc/BRIEF.md
# Pin-Driven Up/Down Event Timer with Capture

This block is a counter whose events all arrive on external pins instead of being derived from the system clock. A count pin advances the value by one on each of its rising edges. A direction pin steers each step: high means up, low means down. A rising edge on a clear pin forces the value to zero, and a rising edge on a snapshot pin copies the live value into a separate capture register. Every pin is brought into the system clock domain through a two-stage synchronizer. Edges are then found by comparing the synchronized level with its previous sample, so a pin held high produces one event and no more.

A synchronous enable input gates counting only. Clear and snapshot keep working while counting is off. The counter wraps modulo 2^W in both directions. A one-cycle wrap pulse marks every wrap, and that pulse appears in the same cycle as the wrapped value. The count width is a parameter (default 16).

Top module: `pin_event_timer`

## Requirements
- R1: After reset deassertion, the count, the capture register and the wrap pulse are all zero.
- R2: When the direction pin is high and counting is enabled, a rising edge on the count pin raises the count by one. The new value appears on the third system clock edge after the pin rises (two synchronizer stages plus the count register).
- R3: When the direction pin is low and counting is enabled, a rising edge on the count pin lowers the count by one, with the same latency as R2.
- R4: A rising edge on the clear pin sets the count to zero with the same latency. If a count edge is detected in the same cycle, the clear takes precedence and the count becomes zero.
- R5: A rising edge on the snapshot pin loads the capture register with the count held just before that cycle's update. If a count edge coincides, the capture register receives the value before the step. At all other times the capture register holds its value.
- R6: Counting up from 2^W-1 gives 0, and counting down from 0 gives 2^W-1. On each such wrap, the wrap output is high for exactly one cycle, coinciding with the wrapped count.
- R7: While the enable input is low, count edges leave the count unchanged, and clear and snapshot edges still take effect.
- R8: A pin held high for many cycles gives exactly one event. Only a fresh low-to-high transition of the synchronized pin counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Synchronous count enable (clear and snapshot ignore it) |
| tickPin | input | 1 | External count clock, asynchronous |
| dirPin | input | 1 | External direction level, 1 = up, 0 = down, asynchronous |
| clearPin | input | 1 | External clear, rising edge active, asynchronous |
| grabPin | input | 1 | External snapshot, rising edge active, asynchronous |
| countVal | output | W | Current count |
| captureVal | output | W | Last captured count |
| wrapPulse | output | 1 | One-cycle pulse on overflow or underflow |

## Verification
The hardest situations to reach are two events landing in the same system clock cycle once they have passed through the synchronizers: a count with a clear, and a count with a snapshot. The bench raises both pins on the same falling clock edge, so they share an identical synchronizer path and their edges are detected in the same cycle. The bench instantiates a 4-bit counter, which makes full sweeps across both wrap points, in both directions, short enough to check every step against an arithmetic model.

// File: rtl/pet_pkg.sv
package pet_pkg;
  typedef struct packed {
    logic inc;
    logic dec;
    logic clr;
    logic grab;
  } petStrobes_t;

  localparam int PIN_TICK  = 0;
  localparam int PIN_DIR   = 1;
  localparam int PIN_CLEAR = 2;
  localparam int PIN_GRAB  = 3;
  localparam int PIN_COUNT = 4;
endpackage

// File: rtl/pet_pin_sync.sv
module pet_pin_sync #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] rawPins,
  output logic [N-1:0] syncLvl,
  output logic [N-1:0] riseEdge
);
  logic [N-1:0] stage1;
  logic [N-1:0] stage2;
  logic [N-1:0] prevLvl;

  for (genvar i = 0; i < N; i++) begin : g_pin
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stage1[i]  <= 1'b0;
        stage2[i]  <= 1'b0;
        prevLvl[i] <= 1'b0;
      end else begin
        stage1[i]  <= rawPins[i];
        stage2[i]  <= stage1[i];
        prevLvl[i] <= stage2[i];
      end
    end
    assign riseEdge[i] = stage2[i] & ~prevLvl[i];
  end

  assign syncLvl = stage2;
endmodule

// File: rtl/pet_ctrl.sv
module pet_ctrl
  import pet_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        tickPin,
  input  logic        dirPin,
  input  logic        clearPin,
  input  logic        grabPin,
  output petStrobes_t stb
);
  logic [PIN_COUNT-1:0] rawPins;
  logic [PIN_COUNT-1:0] syncLvl;
  logic [PIN_COUNT-1:0] riseEdge;
  logic                 stepOk;

  always_comb begin
    rawPins            = '0;
    rawPins[PIN_TICK]  = tickPin;
    rawPins[PIN_DIR]   = dirPin;
    rawPins[PIN_CLEAR] = clearPin;
    rawPins[PIN_GRAB]  = grabPin;
  end

  pet_pin_sync #(.N(PIN_COUNT)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .rawPins (rawPins),
    .syncLvl (syncLvl),
    .riseEdge(riseEdge)
  );

  // clear outranks any step in the same cycle
  assign stepOk = riseEdge[PIN_TICK] & enable & ~riseEdge[PIN_CLEAR];

  always_comb begin
    stb.inc  = stepOk &  syncLvl[PIN_DIR];
    stb.dec  = stepOk & ~syncLvl[PIN_DIR];
    stb.clr  = riseEdge[PIN_CLEAR];
    stb.grab = riseEdge[PIN_GRAB];
  end
endmodule

// File: rtl/pet_datapath.sv
module pet_datapath
  import pet_pkg::*;
#(
  parameter int W = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  petStrobes_t stb,
  output logic [W-1:0] countVal,
  output logic [W-1:0] captureVal,
  output logic         wrapPulse
);
  localparam logic [W-1:0] TOP = {W{1'b1}};
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] nextCount;
  logic         wrapNext;

  always_comb begin
    nextCount = countVal;
    wrapNext  = 1'b0;
    if (stb.clr) begin
      nextCount = '0;
    end else if (stb.inc) begin
      nextCount = countVal + ONE;
      wrapNext  = (countVal == TOP);
    end else if (stb.dec) begin
      nextCount = countVal - ONE;
      wrapNext  = (countVal == '0);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countVal   <= '0;
      captureVal <= '0;
      wrapPulse  <= 1'b0;
    end else begin
      countVal  <= nextCount;
      wrapPulse <= wrapNext;
      if (stb.grab) captureVal <= countVal;
    end
  end
endmodule

// File: rtl/pin_event_timer.sv
module pin_event_timer
  import pet_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         enable,
  input  logic         tickPin,
  input  logic         dirPin,
  input  logic         clearPin,
  input  logic         grabPin,
  output logic [W-1:0] countVal,
  output logic [W-1:0] captureVal,
  output logic         wrapPulse
);
  petStrobes_t stb;

  pet_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .enable  (enable),
    .tickPin (tickPin),
    .dirPin  (dirPin),
    .clearPin(clearPin),
    .grabPin (grabPin),
    .stb     (stb)
  );

  pet_datapath #(.W(W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .countVal  (countVal),
    .captureVal(captureVal),
    .wrapPulse (wrapPulse)
  );
endmodule

// File: rtl/pet_checker.sv
module pet_checker
  import pet_pkg::*;
#(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rstN,
  input logic         enable,
  input petStrobes_t  stb,
  input logic [W-1:0] countVal,
  input logic [W-1:0] captureVal,
  input logic         wrapPulse
);
  a_r4_clear_zero: assert property (@(posedge clk) disable iff (!rstN)
    stb.clr |=> countVal == '0);

  a_r2_step_up: assert property (@(posedge clk) disable iff (!rstN)
    stb.inc |=> countVal == W'($past(countVal) + 1'b1));

  a_r3_step_down: assert property (@(posedge clk) disable iff (!rstN)
    stb.dec |=> countVal == W'($past(countVal) - 1'b1));

  a_r5_snapshot: assert property (@(posedge clk) disable iff (!rstN)
    stb.grab |=> captureVal == $past(countVal));

  a_r5_hold: assert property (@(posedge clk) disable iff (!rstN)
    !stb.grab |=> $stable(captureVal));

  a_r6_wrap_single: assert property (@(posedge clk) disable iff (!rstN)
    wrapPulse |=> !wrapPulse);

  a_r6_wrap_value: assert property (@(posedge clk) disable iff (!rstN)
    wrapPulse |-> (countVal == '0 || countVal == {W{1'b1}}));

  a_r7_disabled_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && !stb.clr) |=> $stable(countVal));

  a_r8_no_double_step: assert property (@(posedge clk) disable iff (!rstN)
    (stb.inc || stb.dec) |=> !(stb.inc || stb.dec));
endmodule

bind pin_event_timer pet_checker #(.W(W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .enable    (enable),
  .stb       (stb),
  .countVal  (countVal),
  .captureVal(captureVal),
  .wrapPulse (wrapPulse)
);

// File: tb/sim_pin_event_timer.sv
module sim_pin_event_timer;
  localparam int  PERIOD = 10;
  localparam int  W      = 4;
  localparam int  MODV   = 1 << W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic tickPin = 1'b0, dirPin = 1'b0, clearPin = 1'b0, grabPin = 1'b0;
  logic [W-1:0] countVal, captureVal;
  logic wrapPulse;

  int checks = 0;
  int failures = 0;
  int expCount = 0;
  int expCap = 0;
  bit finished = 0;

  always #(PERIOD/2) clk = ~clk;

  pin_event_timer #(.W(W)) u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .tickPin(tickPin),
    .dirPin(dirPin), .clearPin(clearPin), .grabPin(grabPin),
    .countVal(countVal), .captureVal(captureVal), .wrapPulse(wrapPulse)
  );

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic waitNeg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // raise the chosen pins, sample after the third edge, then release
  task automatic pulsePins(input bit tk, input bit cl, input bit gr,
                           input int holdExtra);
    tickPin = tk; clearPin = cl; grabPin = gr;
    waitNeg(3);
    waitNeg(holdExtra);
  endtask

  task automatic releasePins();
    tickPin = 0; clearPin = 0; grabPin = 0;
    waitNeg(3);
  endtask

  task automatic setDir(input bit d);
    dirPin = d;
    waitNeg(3);
  endtask

  task automatic stepAndCheck(input bit up, input string req);
    int nxt;
    bit wrapExp;
    nxt = up ? (expCount + 1) % MODV : (expCount + MODV - 1) % MODV;
    wrapExp = up ? (expCount == MODV - 1) : (expCount == 0);
    pulsePins(1, 0, 0, 0);
    expCount = nxt;
    check(req, int'(countVal), expCount);
    check("R6 wrap pulse", int'(wrapPulse), int'(wrapExp));
    waitNeg(1);
    check("R6 wrap one cycle", int'(wrapPulse), 0);
    releasePins();
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    waitNeg(3);
    rstN = 1'b1;
    waitNeg(1);
    // R1 reset state
    check("R1 count", int'(countVal), 0);
    check("R1 capture", int'(captureVal), 0);
    check("R1 wrap", int'(wrapPulse), 0);

    enable = 1'b1;
    // R2 latency: value must not move before the third edge
    tickPin = 1; setDir(1);
    // setDir waited 3 negedges with tick already raised: step done
    expCount = 1;
    check("R2 latency", int'(countVal), 1);
    releasePins();
    tickPin = 1; waitNeg(2);
    check("R2 not before third edge", int'(countVal), 1);
    waitNeg(1);
    expCount = 2;
    check("R2 third edge", int'(countVal), 2);
    releasePins();

    // R2 and R6: sweep up across two wraps
    for (int i = 0; i < 2 * MODV + 3; i++) stepAndCheck(1, "R2 up step");

    // R3 and R6: sweep down across two wraps
    setDir(0);
    for (int i = 0; i < 2 * MODV + 3; i++) stepAndCheck(0, "R3 down step");

    // R8 held level gives a single event
    pulsePins(1, 0, 0, 12);
    expCount = (expCount + MODV - 1) % MODV;
    check("R8 held tick", int'(countVal), expCount);
    releasePins();

    // R5 snapshot alone
    pulsePins(0, 0, 1, 0);
    expCap = expCount;
    check("R5 snapshot", int'(captureVal), expCap);
    releasePins();
    // R5 snapshot with coincident step takes pre-step value
    setDir(1);
    pulsePins(1, 0, 1, 0);
    expCap = expCount;
    expCount = (expCount + 1) % MODV;
    check("R5 coincident capture", int'(captureVal), expCap);
    check("R5 coincident count", int'(countVal), expCount);
    releasePins();
    // R5 capture holds through later steps
    stepAndCheck(1, "R2 up step");
    check("R5 capture hold", int'(captureVal), expCap);

    // R4 clear alone then clear with coincident step
    pulsePins(0, 1, 0, 0);
    expCount = 0;
    check("R4 clear", int'(countVal), 0);
    releasePins();
    for (int i = 0; i < 5; i++) stepAndCheck(1, "R2 up step");
    pulsePins(1, 1, 0, 0);
    expCount = 0;
    check("R4 clear beats step", int'(countVal), 0);
    releasePins();
    for (int i = 0; i < 3; i++) stepAndCheck(1, "R2 up step");

    // R7 disabled: steps ignored, capture and clear still act
    enable = 1'b0;
    for (int i = 0; i < 4; i++) begin
      pulsePins(1, 0, 0, 0);
      check("R7 disabled hold", int'(countVal), expCount);
      check("R7 no wrap", int'(wrapPulse), 0);
      releasePins();
    end
    pulsePins(0, 0, 1, 0);
    expCap = expCount;
    check("R7 capture while disabled", int'(captureVal), expCap);
    releasePins();
    pulsePins(0, 1, 0, 0);
    expCount = 0;
    check("R7 clear while disabled", int'(countVal), 0);
    releasePins();
    setDir(0);
    pulsePins(1, 0, 0, 0);
    check("R7 no underflow while disabled", int'(countVal), 0);
    check("R7 no wrap pulse", int'(wrapPulse), 0);
    releasePins();
    enable = 1'b1;
    stepAndCheck(0, "R3 down step");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule